// File: doc/BRIEF.md
# Montgomery Ladder Scalar Multiplier

This block multiplies a fixed base point G of a prime-field short Weierstrass curve with coefficient a = -3 by a scalar k. It returns Q = k·G in affine coordinates. It keeps two working points in Jacobian coordinates. The first starts at the point at infinity and the second starts at G. For every scalar bit, most significant first, it launches one point addition and one point doubling in parallel. It then routes the two results back into the working points according to the bit. After the last bit it raises Z to the power p-2 by square-and-multiply, forms Z^-2 and Z^-3, and scales X and Y. A result at infinity is reported as (0, 0).

The scalar is not passed as a wide vector. The block drives a word index and reads the addressed word of the scalar on the same cycle. Field width, modulus, base point and scalar geometry are parameters, so the block can be exercised on a small prime. Run time does not depend on the scalar value. No other side-channel measures are taken.

Top module: `ecl_ladder`

## Requirements
- R1: While reset is held and after it is released, busy and done are 0 and qx and qy are 0.
- R2: A start pulse while idle is taken at the next rising edge, and busy is 1 from that edge until done.
- R3: The scalar is scanned from its most significant bit. The first word index driven after a start is KN-1. Word index i carries scalar bits i·KW through i·KW+KW-1, and bit 0 of a word is its least significant bit.
- R4: When k·G is a finite point, qx and qy equal its affine coordinates, each reduced below P_MOD.
- R5: When k·G is the point at infinity, for example k = 0 or a multiple of the order of G, qx and qy are both 0.
- R6: done is high for exactly one cycle per accepted start, and busy is 0 in that cycle.
- R7: A start raised while busy is ignored. The running result is unaffected, no second done follows, and busy is 0 in the cycle after done.
- R8: qx and qy keep their value from one done until the next, regardless of scalar input changes.
- R9: done is observed exactly 2·KN·KW + FW + 3 rising edges after the edge that accepted the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new multiplication |
| k_idx | output | IDXW | Index of the scalar word being read |
| k_word | input | KW | Scalar word addressed by k_idx |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse when qx and qy are new |
| qx | output | FW | Affine x of k·G, or 0 at infinity |
| qy | output | FW | Affine y of k·G, or 0 at infinity |

## Verification
A corrupted working point or a wrong swap decision never shows at the ports while a run is in progress. It only appears as a wrong qx/qy pair at the next done. Because every ladder step feeds the following steps, a single bad step almost always changes the final coordinates. A step that misses the infinity case, or an inversion with the wrong exponent, therefore shows on the first scalar that reaches it. For this reason the full scalar range is swept against an affine reference. Faults in the sequence, such as a wrong scan order, a wrong cycle count or an extra done, show at once as a shifted done or a wrong first word index.

// File: rtl/ecl_pkg.sv
// Shared field helpers and controller state encoding.
// Assumes operands below the modulus and a field width of at most 32 bits.
package ecl_pkg;
    typedef logic [63:0] fe_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_STEP, ST_WAIT, ST_IGO, ST_INV
    } ctl_t;

    function automatic fe_t fadd(fe_t a, fe_t b, fe_t p);
        fe_t s;
        s = a + b;
        return (s >= p) ? s - p : s;
    endfunction

    function automatic fe_t fsub(fe_t a, fe_t b, fe_t p);
        return (a >= b) ? a - b : a + p - b;
    endfunction

    function automatic fe_t fmul(fe_t a, fe_t b, fe_t p);
        return (a * b) % p;
    endfunction

    // Division by two modulo an odd p.
    function automatic fe_t fhalf(fe_t a, fe_t p);
        return a[0] ? (a + p) >> 1 : a >> 1;
    endfunction
endpackage

// File: rtl/ecl_pt_add.sv
// Jacobian point addition R = P + Q with one cycle of latency.
// Assumes P != Q. P == -Q gives Z = 0. An operand at infinity (Z = 0) passes the other through.
module ecl_pt_add
    import ecl_pkg::*;
#(
    parameter int FW = 8,
    parameter logic [FW-1:0] P_MOD = 8'd23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [FW-1:0] px, py, pz,
    input  logic [FW-1:0] qx, qy, qz,
    output logic          rdy,
    output logic [FW-1:0] rx, ry, rz
);
    localparam fe_t PM = fe_t'(P_MOD);

    fe_t ax, ay, az, bx, by, bz;
    fe_t pz2, qz2, u1, u2, s1, s2, h, r, h2, h3, v, nx, ny, nz;

    // Next sum from the current operands.
    always_comb begin
        ax = fe_t'(px); ay = fe_t'(py); az = fe_t'(pz);
        bx = fe_t'(qx); by = fe_t'(qy); bz = fe_t'(qz);
        pz2 = fmul(az, az, PM);
        qz2 = fmul(bz, bz, PM);
        u1  = fmul(ax, qz2, PM);
        u2  = fmul(bx, pz2, PM);
        s1  = fmul(ay, fmul(bz, qz2, PM), PM);
        s2  = fmul(by, fmul(az, pz2, PM), PM);
        h   = fsub(u2, u1, PM);
        r   = fsub(s2, s1, PM);
        h2  = fmul(h, h, PM);
        h3  = fmul(h, h2, PM);
        v   = fmul(u1, h2, PM);
        nz  = fmul(fmul(az, bz, PM), h, PM);
        nx  = fsub(fsub(fmul(r, r, PM), h3, PM), fadd(v, v, PM), PM);
        ny  = fsub(fmul(fsub(v, nx, PM), r, PM), fmul(s1, h3, PM), PM);
        if (az == '0) begin
            nx = bx; ny = by; nz = bz;
        end else if (bz == '0) begin
            nx = ax; ny = ay; nz = az;
        end
    end

    // Capture the sum and flag it on a go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0; rx <= '0; ry <= '0; rz <= '0;
        end else begin
            rdy <= go;
            if (go) begin
                rx <= nx[FW-1:0]; ry <= ny[FW-1:0]; rz <= nz[FW-1:0];
            end
        end
    end
endmodule

// File: rtl/ecl_pt_dbl.sv
// Jacobian point doubling R = 2P for a = -3, with one cycle of latency.
// Infinity (Z = 0) and points with Y = 0 both yield Z = 0.
module ecl_pt_dbl
    import ecl_pkg::*;
#(
    parameter int FW = 8,
    parameter logic [FW-1:0] P_MOD = 8'd23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [FW-1:0] px, py, pz,
    output logic          rdy,
    output logic [FW-1:0] rx, ry, rz
);
    localparam fe_t PM = fe_t'(P_MOD);

    fe_t x, y, z, z2, d, m, y2, a4, s, c8, nx, ny, nz;

    // Next double from the current operand.
    always_comb begin
        x  = fe_t'(px); y = fe_t'(py); z = fe_t'(pz);
        z2 = fmul(z, z, PM);
        d  = fmul(fsub(x, z2, PM), fadd(x, z2, PM), PM);
        m  = fadd(fadd(d, d, PM), d, PM);
        y2 = fadd(y, y, PM);
        nz = fmul(z, y2, PM);
        a4 = fmul(y2, y2, PM);
        s  = fmul(x, a4, PM);
        c8 = fhalf(fmul(a4, a4, PM), PM);
        nx = fsub(fmul(m, m, PM), fadd(s, s, PM), PM);
        ny = fsub(fmul(fsub(s, nx, PM), m, PM), c8, PM);
    end

    // Capture the double and flag it on a go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0; rx <= '0; ry <= '0; rz <= '0;
        end else begin
            rdy <= go;
            if (go) begin
                rx <= nx[FW-1:0]; ry <= ny[FW-1:0]; rz <= nz[FW-1:0];
            end
        end
    end
endmodule

// File: rtl/ecl_inv.sv
// Forms Z^-2 and Z^-3 as Z^(p-2) squared and cubed.
// Runs left-to-right square-and-multiply over FW exponent bits, then one finishing cycle.
// A zero Z yields zeros.
module ecl_inv
    import ecl_pkg::*;
#(
    parameter int FW = 8,
    parameter logic [FW-1:0] P_MOD = 8'd23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [FW-1:0] z,
    output logic          rdy,
    output logic [FW-1:0] zi2,
    output logic [FW-1:0] zi3
);
    localparam fe_t PM = fe_t'(P_MOD);
    localparam logic [FW-1:0] EXP = P_MOD - FW'(2);
    localparam int CW = (FW > 1) ? $clog2(FW) : 1;

    fe_t acc, zr, sq, stepv, fin2;
    logic run, fin;
    logic [CW-1:0] cnt;

    // One square-and-multiply step and the final powers.
    always_comb begin
        sq    = fmul(acc, acc, PM);
        stepv = EXP[cnt] ? fmul(sq, zr, PM) : sq;
        fin2  = fmul(acc, acc, PM);
    end

    // Exponent walk, then publish both powers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0; zr <= '0; run <= 1'b0; fin <= 1'b0; cnt <= '0;
            rdy <= 1'b0; zi2 <= '0; zi3 <= '0;
        end else begin
            rdy <= 1'b0;
            fin <= 1'b0;
            if (go) begin
                acc <= fe_t'(1); zr <= fe_t'(z); run <= 1'b1; cnt <= CW'(FW - 1);
            end else if (run) begin
                acc <= stepv;
                if (cnt == '0) begin
                    run <= 1'b0; fin <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (fin) begin
                rdy <= 1'b1;
                zi2 <= fin2[FW-1:0];
                zi3 <= fmul(fin2, acc, PM)[FW-1:0];
            end
        end
    end
endmodule

// File: rtl/ecl_ladder.sv
// Ladder controller computing Q = k*G in affine form.
// Two working points: R0 starts at infinity (1,1,0), R1 at G (GX,GY,1).
// Each scalar bit, most significant first, costs two cycles; the affine
// conversion costs FW+3 more. Start is ignored while busy.
module ecl_ladder
    import ecl_pkg::*;
#(
    parameter int FW = 8,
    parameter int KW = 4,
    parameter int KN = 2,
    parameter logic [FW-1:0] P_MOD = 8'd23,
    parameter logic [FW-1:0] GX = 8'd3,
    parameter logic [FW-1:0] GY = 8'd5,
    localparam int IDXW = (KN > 1) ? $clog2(KN) : 1,
    localparam int BW = (KW > 1) ? $clog2(KW) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic [IDXW-1:0] k_idx,
    input  logic [KW-1:0]   k_word,
    output logic            busy,
    output logic            done,
    output logic [FW-1:0]   qx,
    output logic [FW-1:0]   qy
);
    localparam fe_t PM = fe_t'(P_MOD);

    ctl_t st;
    logic [FW-1:0] r0x, r0y, r0z, r1x, r1y, r1z;
    logic [IDXW-1:0] widx;
    logic [BW-1:0] bidx;
    logic kbit, cur_bit, last_bit;
    logic add_go, add_rdy, dbl_rdy, inv_rdy;
    logic [FW-1:0] sx, sy, sz, tx, ty, tz, dx, dy, dz, zi2, zi3;

    // Scalar addressing and per-step control.
    always_comb begin
        k_idx    = widx;
        cur_bit  = k_word[bidx];
        add_go   = (st == ST_STEP);
        last_bit = (widx == '0) && (bidx == '0);
        busy     = (st != ST_IDLE);
        dx = cur_bit ? r1x : r0x;
        dy = cur_bit ? r1y : r0y;
        dz = cur_bit ? r1z : r0z;
    end

    ecl_pt_add #(.FW(FW), .P_MOD(P_MOD)) u_add (
        .clk(clk), .rst_n(rst_n), .go(add_go),
        .px(r0x), .py(r0y), .pz(r0z), .qx(r1x), .qy(r1y), .qz(r1z),
        .rdy(add_rdy), .rx(sx), .ry(sy), .rz(sz));

    ecl_pt_dbl #(.FW(FW), .P_MOD(P_MOD)) u_dbl (
        .clk(clk), .rst_n(rst_n), .go(add_go),
        .px(dx), .py(dy), .pz(dz),
        .rdy(dbl_rdy), .rx(tx), .ry(ty), .rz(tz));

    ecl_inv #(.FW(FW), .P_MOD(P_MOD)) u_inv (
        .clk(clk), .rst_n(rst_n), .go(st == ST_IGO), .z(r0z),
        .rdy(inv_rdy), .zi2(zi2), .zi3(zi3));

    // Sequencer: init, ladder steps, conversion, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; done <= 1'b0; qx <= '0; qy <= '0; kbit <= 1'b0;
            r0x <= '0; r0y <= '0; r0z <= '0; r1x <= '0; r1y <= '0; r1z <= '0;
            widx <= '0; bidx <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    r0x <= FW'(1); r0y <= FW'(1); r0z <= '0;
                    r1x <= GX; r1y <= GY; r1z <= FW'(1);
                    widx <= IDXW'(KN - 1); bidx <= BW'(KW - 1);
                    st <= ST_STEP;
                end
                ST_STEP: begin
                    kbit <= cur_bit;
                    st   <= ST_WAIT;
                end
                ST_WAIT: if (add_rdy && dbl_rdy) begin
                    if (kbit) begin
                        r1x <= tx; r1y <= ty; r1z <= tz;
                        r0x <= sx; r0y <= sy; r0z <= sz;
                    end else begin
                        r0x <= tx; r0y <= ty; r0z <= tz;
                        r1x <= sx; r1y <= sy; r1z <= sz;
                    end
                    if (last_bit) begin
                        st <= ST_IGO;
                    end else begin
                        if (bidx == '0) begin
                            bidx <= BW'(KW - 1);
                            widx <= widx - 1'b1;
                        end else begin
                            bidx <= bidx - 1'b1;
                        end
                        st <= ST_STEP;
                    end
                end
                ST_IGO: st <= ST_INV;
                ST_INV: if (inv_rdy) begin
                    if (r0z == '0) begin
                        qx <= '0; qy <= '0;
                    end else begin
                        qx <= fmul(fe_t'(r0x), fe_t'(zi2), PM)[FW-1:0];
                        qy <= fmul(fe_t'(r0y), fe_t'(zi3), PM)[FW-1:0];
                    end
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ecl_ladder_chk.sv
// Port-level protocol checks for ecl_ladder, attached by bind.
module ecl_ladder_chk #(
    parameter int FW = 8,
    parameter int KN = 2,
    parameter logic [FW-1:0] P_MOD = 8'd23,
    parameter int IDXW = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [IDXW-1:0] k_idx,
    input logic [FW-1:0]   qx,
    input logic [FW-1:0]   qy
);
    logic seen;

    // Marks that at least one post-reset edge has been sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $rose(busy)) |-> $past(start));
    a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(k_idx) < KN);
    a_r4_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (qx < P_MOD && qy < P_MOD));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !done) |-> ($stable(qx) && $stable(qy)));
endmodule

bind ecl_ladder ecl_ladder_chk #(.FW(FW), .KN(KN), .P_MOD(P_MOD), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .k_idx(k_idx), .qx(qx), .qy(qy));

// File: tb/ecl_ladder_tb.sv
// Sweeps every 8-bit scalar on y^2 = x^3 - 3x + 7 over GF(23) with G = (3,5)
// and compares against repeated affine addition.
module ecl_ladder_tb;
    localparam int FW = 8, KW = 4, KN = 2, P = 23;
    localparam int LAT = 2 * KN * KW + FW + 3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [0:0] k_idx;
    logic [KW-1:0] k_word;
    logic busy, done;
    logic [FW-1:0] qx, qy;
    logic [KW*KN-1:0] kreg = '0;
    int tests = 0, fails = 0, cycles = 0;

    always #10 clk = ~clk;

    assign k_word = kreg[k_idx*KW +: KW];

    ecl_ladder #(.FW(FW), .KW(KW), .KN(KN), .P_MOD(8'd23), .GX(8'd3), .GY(8'd5)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .k_idx(k_idx), .k_word(k_word),
        .busy(busy), .done(done), .qx(qx), .qy(qy));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int md(input int v);
        return ((v % P) + P) % P;
    endfunction

    function automatic int finv(input int a);
        for (int i = 1; i < P; i++) if (md(a * i) == 1) return i;
        return 0;
    endfunction

    // Affine reference addition with infinity flag.
    task automatic padd(input bit ai, input int ax, input int ay,
                        input bit bi, input int bx, input int by,
                        output bit ri, output int rx, output int ry);
        int lam;
        if (ai) begin ri = bi; rx = bx; ry = by; return; end
        if (bi) begin ri = ai; rx = ax; ry = ay; return; end
        if (ax == bx) begin
            if (md(ay + by) == 0) begin ri = 1; rx = 0; ry = 0; return; end
            lam = md(md(3 * ax * ax - 3) * finv(md(2 * ay)));
        end else begin
            lam = md(md(by - ay) * finv(md(bx - ax)));
        end
        ri = 0;
        rx = md(lam * lam - ax - bx);
        ry = md(lam * (ax - rx) - ay);
    endtask

    // One multiplication; optionally raises start mid-run (R7).
    task automatic run_k(input int k, input bit inf, input int ex, input int ey, input bit poke);
        int n, dones;
        @(negedge clk);
        kreg = (KW*KN)'(k);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        chk(k_idx == 1'(KN - 1), "R3 first word index", k_idx, KN - 1);
        n = 0; dones = 0;
        while (!done && n < 200) begin
            @(posedge clk); #1;
            n++;
            if (poke && n == 5) start = 1'b1;
            if (poke && n == 6) start = 1'b0;
        end
        chk(n == LAT, "R9 latency", n, LAT);
        if (inf) begin
            chk(qx == 0 && qy == 0, "R5 infinity x", qx, 0);
        end else begin
            chk(qx == FW'(ex), "R4 qx", qx, ex);
            chk(qy == FW'(ey), "R4 qy", qy, ey);
        end
        @(posedge clk); #1;
        chk(done == 1'b0, "R6 done one cycle", done, 0);
        if (poke) chk(busy == 1'b0, "R7 start while busy ignored", busy, 0);
    endtask

    // Watchdog: an overlong run is a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit ri;
        int rx, ry;
        bit ni;
        int nx, ny;
        logic [FW-1:0] hx, hy;
        repeat (3) @(posedge clk);
        #1;
        chk(busy == 0 && done == 0, "R1 reset ctl", busy, 0);
        chk(qx == 0 && qy == 0, "R1 reset outputs", qx, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(busy == 0 && qx == 0 && qy == 0, "R1 after release", busy, 0);
        ri = 1; rx = 0; ry = 0;
        for (int k = 0; k < 256; k++) begin
            run_k(k, ri, rx, ry, (k % 37) == 3);
            padd(ri, rx, ry, 1'b0, 3, 5, ni, nx, ny);
            ri = ni; rx = nx; ry = ny;
        end
        // R8: outputs hold while idle and the scalar input changes.
        hx = qx; hy = qy;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); kreg = kreg + 8'd29;
        end
        #1;
        chk(qx == hx, "R8 qx hold", qx, hx);
        chk(qy == hy, "R8 qy hold", qy, hy);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule